// File: doc/BRIEF.md
# Telecom Bit-Clock and Frame-Sync Synthesizer

This block builds a serial-line bit clock and a frame sync from one fast system clock. One of several slow timing strobes is chosen as the reference. A period meter counts system-clock cycles between reference strobes. A phase accumulator then emits bit-clock enables at a programmable multiple of the reference rate, which is a small digital frequency-locked loop. A frame divider counts those enables and raises a frame-sync level once per frame. Every output is a clock-enable or a level sampled on the system clock. No derived clock is made.

One 16-bit control word sets the block up. It selects the reference line, the multiplication factor and the frame length, and one bit switches the synthesizer on. While that bit is clear, the chosen line's own bit strobe and frame input pass through unchanged. Any write to the word restarts the measurement, so the loop locks again on the new settings. A setting that would run the bit clock too fast for the system clock is flagged, and so is a reference that is too slow for the meter. In both cases the outputs stay idle.

Top module: `fs_clk_synth`

## Requirements
- R1: After reset the control word reads 0x0000, and `gdcl_en`, `fsc`, `lock` and `rate_err` are all 0.
- R2: A write stores `wr_data` masked with 0x80FF. `rd_data` shows the stored word from the cycle after the write, and bits 14..8 always read as 0.
- R3: While control bit 15 is 0 (pass-through), `gdcl_en` and `fsc` equal the selected line of `ref_tick` and `frm_in` one cycle later, and `lock` stays 0.
- R4: Control bits 7..6 give the index of the `ref_tick`/`frm_in` line that is used. Activity on the other lines has no effect on any output.
- R5: With bit 15 set, the first reference strobe after a write starts the meter, and each later strobe completes one period measurement. `lock` rises the cycle after a strobe whose measurement equals the one before it and is in range, so on a steady reference this is the third strobe. `lock` falls after any measurement that differs.
- R6: While locked with reference period P cycles, any window of k·P cycles holds exactly k·M `gdcl_en` pulses, where M = 2^(bits 2..0 + 1).
- R7: If a measured period P satisfies P ≤ 20·M, `rate_err` is 1, `lock` is 0 and no `gdcl_en` pulses appear.
- R8: A reference period of up to 16384 cycles can lock. If 16384 cycles pass after a strobe with no new strobe, `rate_err` becomes 1 and `lock` stays 0.
- R9: While locked, `fsc` rises in the same cycle as a `gdcl_en` pulse, once every D pulses, where D = 2^(bits 5..3 + 2). It falls at the next `gdcl_en` pulse.
- R10: Any write clears `lock` in the next cycle. From the second cycle after the write, no `gdcl_en` pulse appears until lock is regained.
- R11: The word 0x802B with a 64 kHz-class reference yields M = 16, D = 128, reference line 0 and the synthesizer on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 16 | Control word to store |
| rd_data | output | 16 | Stored control word |
| ref_tick | input | 4 | Candidate reference / bit strobes, one per line |
| frm_in | input | 4 | Candidate external frame inputs, one per line |
| gdcl_en | output | 1 | Bit-clock enable pulse |
| fsc | output | 1 | Frame-sync level |
| lock | output | 1 | Loop locked |
| rate_err | output | 1 | Configuration or reference out of range |

## Verification
The bench probes the range limits from both sides: a period of exactly 20·M, which must be rejected, against 20·M plus one, and 16384 cycles, which must lock, against 16385. A design with an off-by-one in the meter count or the limit compare would lock where it must not, or fail to lock where it should. Lock timing is checked to the cycle. A loop that locked on the first measurement, or that counted the arming strobe as a measurement, would show `lock` one period early. Noise on the unselected lines, pulse counts over whole reference periods, and the spacing and falling edge of `fsc` expose a wrong line index, a lossy accumulator, or a frame counter that is off by one or drifts from the bit enables.

// File: rtl/fs_synth_pkg.sv
package fs_synth_pkg;
  localparam int REG_W   = 16;
  localparam int MUL_LSB = 0;
  localparam int MUL_W   = 3;
  localparam int DIV_LSB = 3;
  localparam int DIV_W   = 3;
  localparam int SRC_LSB = 6;
  localparam int SRC_W   = 2;
  localparam int RUN_BIT = 15;

  localparam logic [REG_W-1:0] REG_MASK =
      REG_W'((((1 << MUL_W) - 1) << MUL_LSB) |
             (((1 << DIV_W) - 1) << DIV_LSB) |
             (((1 << SRC_W) - 1) << SRC_LSB) |
             (1 << RUN_BIT));

  typedef struct packed {
    logic             run;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
    logic [MUL_W-1:0] mul;
  } cfg_t;

  function automatic cfg_t unpack_cfg(input logic [REG_W-1:0] w);
    cfg_t c;
    c.run = w[RUN_BIT];
    c.src = w[SRC_LSB +: SRC_W];
    c.div = w[DIV_LSB +: DIV_W];
    c.mul = w[MUL_LSB +: MUL_W];
    return c;
  endfunction
endpackage

// File: rtl/fs_period_meter.sv
module fs_period_meter #(
  parameter int CNT_W     = 14,
  parameter int FACT_W    = 9,
  parameter int MIN_RATIO = 20,
  localparam int PER_W    = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              tick,
  input  logic [FACT_W-1:0] factor,
  output logic              locked,
  output logic              rate_err,
  output logic [PER_W-1:0]  period
);
  logic             armed;
  logic             have_prev;
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] prev_p;
  logic [PER_W-1:0] meas;
  logic [31:0]      lim;
  logic             meas_ok;

  assign meas    = {1'b0, cnt} + PER_W'(1);
  assign lim     = 32'(MIN_RATIO) * 32'(factor);
  assign meas_ok = 32'(meas) > lim;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      armed     <= 1'b0;
      have_prev <= 1'b0;
      cnt       <= '0;
      prev_p    <= '0;
      period    <= '0;
      locked    <= 1'b0;
      rate_err  <= 1'b0;
    end else if (!armed) begin
      cnt <= '0;
      if (tick) armed <= 1'b1;
    end else if (tick) begin
      cnt       <= '0;
      prev_p    <= meas;
      have_prev <= 1'b1;
      period    <= meas;
      rate_err  <= !meas_ok;
      locked    <= have_prev && (meas == prev_p) && meas_ok;
    end else if (cnt == {CNT_W{1'b1}}) begin
      // reference slower than the meter can span
      cnt       <= '0;
      armed     <= 1'b0;
      have_prev <= 1'b0;
      locked    <= 1'b0;
      rate_err  <= 1'b1;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  p_lock_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(tick));
  p_lock_not_err_r7: assert property (@(posedge clk) disable iff (rst)
    locked |-> !rate_err);
endmodule

// File: rtl/fs_phase_nco.sv
module fs_phase_nco #(
  parameter int PER_W  = 15,
  parameter int FACT_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [FACT_W-1:0] factor,
  input  logic [PER_W-1:0]  period,
  output logic              pulse
);
  logic [PER_W-1:0] acc;
  logic [PER_W:0]   sum;
  logic             wrap;

  assign sum  = {1'b0, acc} + (PER_W+1)'(factor);
  assign wrap = sum >= {1'b0, period};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else if (wrap) begin
      acc   <= PER_W'(sum - {1'b0, period});
      pulse <= 1'b1;
    end else begin
      acc   <= PER_W'(sum);
      pulse <= 1'b0;
    end
  end

  p_acc_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    run |-> (acc < period));
endmodule

// File: rtl/fs_frame_div.sv
module fs_frame_div #(
  parameter int DIV_W     = 3,
  parameter int DIV_SHIFT = 2,
  localparam int FC_W     = (1 << DIV_W) + DIV_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             fsc
);
  logic [FC_W-1:0] cnt;
  logic [FC_W-1:0] last;

  assign last = (FC_W'(1) << (32'(div) + DIV_SHIFT)) - FC_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      fsc <= 1'b0;
    end else if (en) begin
      if (cnt == last) begin
        cnt <= '0;
        fsc <= 1'b1;
      end else begin
        cnt <= cnt + FC_W'(1);
        fsc <= 1'b0;
      end
    end
  end

  p_fsc_on_enable_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(fsc) |-> $past(en));
endmodule

// File: rtl/fs_clk_synth.sv
module fs_clk_synth
  import fs_synth_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int MIN_RATIO = 20,
  parameter int DIV_SHIFT = 2,
  localparam int NSRC     = 1 << SRC_W,
  localparam int FACT_W   = (1 << MUL_W) + 1,
  localparam int PER_W    = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NSRC-1:0]  ref_tick,
  input  logic [NSRC-1:0]  frm_in,
  output logic             gdcl_en,
  output logic             fsc,
  output logic             lock,
  output logic             rate_err
);
  logic [REG_W-1:0]  cfg_q;
  cfg_t              cfg;
  logic [FACT_W-1:0] factor;
  logic              restart;
  logic              tick_sel;
  logic              frm_sel;
  logic              locked;
  logic              err;
  logic [PER_W-1:0]  period;
  logic              nco_pulse;
  logic              fsc_int;
  logic              gdcl_q;
  logic              byp_fsc_q;

  assign cfg      = unpack_cfg(cfg_q);
  assign factor   = FACT_W'(1) << ({1'b0, cfg.mul} + 4'd1);
  assign restart  = wr_en || !cfg.run;
  assign tick_sel = ref_tick[cfg.src];
  assign frm_sel  = frm_in[cfg.src];

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data & REG_MASK;
  end

  fs_period_meter #(
    .CNT_W(CNT_W), .FACT_W(FACT_W), .MIN_RATIO(MIN_RATIO)
  ) u_meter (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick_sel),
    .factor(factor), .locked(locked), .rate_err(err), .period(period)
  );

  fs_phase_nco #(.PER_W(PER_W), .FACT_W(FACT_W)) u_nco (
    .clk(clk), .rst(rst), .run(locked), .factor(factor),
    .period(period), .pulse(nco_pulse)
  );

  fs_frame_div #(.DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT)) u_frame (
    .clk(clk), .rst(rst), .run(locked), .en(nco_pulse),
    .div(cfg.div), .fsc(fsc_int)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gdcl_q    <= 1'b0;
      byp_fsc_q <= 1'b0;
    end else begin
      gdcl_q    <= cfg.run ? (nco_pulse && locked) : tick_sel;
      byp_fsc_q <= frm_sel;
    end
  end

  assign gdcl_en  = gdcl_q;
  assign fsc      = cfg.run ? fsc_int : byp_fsc_q;
  assign lock     = locked;
  assign rate_err = err;
  assign rd_data  = cfg_q;

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~REG_MASK) == '0);
  p_bypass_no_lock_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg.run |-> !lock);
  p_idle_unlocked_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.run) && !$past(locked)) |-> !gdcl_en);
endmodule

// File: tb/fs_clk_synth_tb.sv
`timescale 1ns/1ps
module fs_clk_synth_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [3:0]  ref_tick;
  logic [3:0]  frm_in;
  logic        gdcl_en, fsc, lock, rate_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int per = 1, selsrc = 0, ph = 0, dexp = 4;
  int gcnt = 0, gsince = 0, rise_checks = 0;
  bit frame_on = 1'b0, seen = 1'b0, fsc_prev = 1'b0;

  always #10 clk = ~clk;

  fs_clk_synth u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ref_tick(ref_tick), .frm_in(frm_in), .gdcl_en(gdcl_en), .fsc(fsc),
    .lock(lock), .rate_err(rate_err)
  );

  function automatic int fact_of(input int c); return 1 << (c + 1); endfunction
  function automatic int frame_of(input int f); return 1 << (f + 2); endfunction
  function automatic bit bad_of(input int p, input int m);
    return (p <= 20 * m) || (p > 16384);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] tv, input logic [3:0] fv);
    ref_tick = tv;
    frm_in   = fv;
    @(negedge clk);
    if (gdcl_en) begin gcnt++; gsince++; end
    if (frame_on) begin
      if (fsc && !fsc_prev) begin
        chk("R9 fsc rise on gdcl_en", int'(gdcl_en), 1);
        if (seen) begin
          chk("R9 enables per frame", gsince, dexp);
          rise_checks++;
        end
        seen   = 1'b1;
        gsince = 0;
      end
      if (!fsc && fsc_prev) chk("R9 fsc fall on gdcl_en", int'(gdcl_en), 1);
    end
    fsc_prev = fsc;
  endtask

  task automatic step_ref(input int n);
    for (int i = 0; i < n; i++) begin
      logic [3:0] tv;
      tv = 4'($urandom) & 4'($urandom) & 4'($urandom);
      tv[selsrc] = (ph % per) == 0;
      ph++;
      cyc(tv, 4'($urandom));
    end
  endtask

  task automatic wr(input logic [15:0] d);
    frame_on = 1'b0;
    wr_en    = 1'b1;
    wr_data  = d;
    cyc(4'h0, 4'h0);
    wr_en    = 1'b0;
    ph       = 0;
  endtask

  task automatic run_cfg(input int c, input int f, input int s, input int p,
                         input int k, input string tag);
    int  m;
    bit  bad;
    m      = fact_of(c);
    bad    = bad_of(p, m);
    per    = p;
    selsrc = s;
    dexp   = frame_of(f);
    wr(16'(32'h8000 | (s << 6) | (f << 3) | c));
    step_ref(2 * p);
    chk({tag, " R5 no lock before third strobe"}, int'(lock), 0);
    step_ref(1);
    chk({tag, " R5 lock after third strobe"}, int'(lock), int'(!bad));
    chk({tag, " R7/R8 rate_err"}, int'(rate_err), int'(bad));
    step_ref(2);
    gcnt     = 0;
    gsince   = 0;
    seen     = 1'b0;
    frame_on = !bad;
    step_ref(k * p);
    chk({tag, " R6/R7 gdcl pulses in window"}, gcnt, bad ? 0 : k * m);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; ref_tick = '0; frm_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 gdcl_en", int'(gdcl_en), 0);
    chk("R1 fsc", int'(fsc), 0);
    chk("R1 lock", int'(lock), 0);
    chk("R1 rate_err", int'(rate_err), 0);

    // R2 reserved bits masked
    wr(16'hFFFF);
    chk("R2 reserved bits zero", int'(rd_data), 16'h80FF);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      wr(d);
      chk("R2 readback", int'(rd_data), int'(d & 16'h80FF));
    end

    // R3 / R4 pass-through on each line, with noise on the others
    for (int s = 0; s < 4; s++) begin
      wr(16'(s << 6) | 16'h002B);
      for (int i = 0; i < 12; i++) begin
        logic [3:0] tv, fv;
        tv = 4'($urandom);
        fv = 4'($urandom);
        cyc(tv, fv);
        chk("R3/R4 bypass gdcl_en", int'(gdcl_en), int'(tv[s]));
        chk("R3/R4 bypass fsc", int'(fsc), int'(fv[s]));
        chk("R3 bypass lock", int'(lock), 0);
      end
    end

    // R11 required configuration, R9 frames
    rise_checks = 0;
    run_cfg(3, 5, 0, 800, 24, "R11");
    chk("R11 word read back", int'(rd_data), 16'h802B);
    chk("R9 frame spacing observed", int'(rise_checks > 0), 1);

    // R10 write while running drops lock and silences output
    wr(16'h802B);
    chk("R10 lock cleared after write", int'(lock), 0);
    gcnt = 0;
    step_ref(1600);
    chk("R10 no gdcl while relocking", gcnt, 0);
    chk("R10 still unlocked", int'(lock), 0);
    step_ref(1);
    chk("R10 relocked", int'(lock), 1);

    // R7 rate-limit boundary, both sides
    run_cfg(3, 0, 1, 320, 2, "R7 at limit");
    run_cfg(3, 0, 2, 321, 2, "R7 above limit");

    // random configurations
    for (int i = 0; i < 6; i++) begin
      int c, f, s, p, m, k;
      c = $urandom_range(0, 3);
      f = $urandom_range(0, 2);
      s = $urandom_range(0, 3);
      m = fact_of(c);
      p = 20 * m + $urandom_range(1, 100);
      k = 3 * frame_of(f) / m + 4;
      rise_checks = 0;
      run_cfg(c, f, s, p, k, "R6 random");
      chk("R9 random frames observed", int'(rise_checks > 0), 1);
    end

    // R8 slowest reference boundary
    run_cfg(0, 0, 3, 16384, 1, "R8 slowest ok");
    run_cfg(0, 0, 0, 16385, 1, "R8 too slow");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule